// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Option

This block is a first-in first-out buffer that joins a write-clock domain to a read-clock domain. The two clocks may be unrelated or may be the same clock. A producer presents a word with a write enable. A consumer takes words with a read enable. Each side owns one status flag, and a one-bit mode captured during full reset sets what that flag means.

In standard mode the write flag reports Full and the read flag reports Empty. A stored word reaches `rd_data` only on the read-clock edge that takes a read request. In fall-through mode the write flag reports Input Ready and the read flag reports Output Ready. The oldest word is presented on `rd_data` without any request, and a read enable consumes it. In fall-through terms the stream rules are as follows. `rd_flag` is the valid signal and `rd_en` is the ready signal, and a word leaves only on an edge where both are high. `wr_flag` is the ready signal for the producer, and a write presented while it is low is dropped. There is no other back-pressure path.

Two more controls act on the pointers without a full reconfiguration. A partial reset empties the FIFO and leaves the captured mode in place. A retransmit request rewinds the read pointer to memory location 0, so that the words written since the last reset are delivered again.

Top module: `dual_clock_fifo`

## Requirements
- R1: While `rst_n` is low, the block captures `mode_sel` (1 = fall-through, 0 = standard). After a full reset, standard mode shows `wr_flag`=0 (not full) and `rd_flag`=1 (empty), and fall-through mode shows `wr_flag`=1 (input ready) and `rd_flag`=0 (no output).
- R2: In standard mode a written word stays in memory and `rd_data` does not change until a read. A read enable sampled while not empty loads the oldest word into `rd_data` on that read-clock edge, and words come out in write order.
- R3: In fall-through mode the oldest word appears on `rd_data` with `rd_flag`=1 and no request. A read enable sampled while `rd_flag`=1 consumes that word.
- R4: With DEPTH memory locations, standard `wr_flag` is 1 exactly when DEPTH words are stored. In fall-through mode `wr_flag` drops to 0 when DEPTH words are stored in memory behind the presented word, which is DEPTH+1 words in total. The flags settle within a few cycles of each clock.
- R5: A write while the FIFO is full is ignored and stored words are unchanged.
- R6: A read enable while standard `rd_flag`=1 or fall-through `rd_flag`=0 is ignored: `rd_data` and the read position stay as they are.
- R7: A partial reset (`prst_n` low) empties the FIFO and keeps the mode captured at the last full reset, whatever the value of `mode_sel`.
- R8: A retransmit request is `rt_n`=0 with `rt_mode`=1, sampled on a read-clock edge. On the 4th read-clock edge after that, the read pointer returns to location 0 and the write pointer stays as it is. While the request is pending, reads are ignored and the read flag shows no data.
- R9: `rt_n`=0 with `rt_mode`=0 has no effect.
- R10: Pointers cross between domains as Gray code through two-flop synchronizers. Each pointer changes at most one Gray bit per edge, except on clear or rewind, so data order holds across pointer wraparound.
- R11: In fall-through mode, while `rd_flag`=1 and no read is requested, `rd_data` holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Full reset, active low; captures the mode |
| prst_n | input | 1 | Partial reset, active low; flushes pointers only |
| mode_sel | input | 1 | Mode sampled during full reset (1 = fall-through) |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to store |
| wr_flag | output | 1 | Full (standard) or Input Ready (fall-through) |
| rd_en | input | 1 | Read request or consume |
| rd_data | output | DW | Output word |
| rd_flag | output | 1 | Empty (standard) or Output Ready (fall-through) |
| rt_n | input | 1 | Retransmit request, active low |
| rt_mode | input | 1 | Enables the retransmit request |

## Verification
The bench fills and drains the FIFO at every occupancy in both modes, passing the pointers through wraparound. A design with a wrong Gray conversion or full compare would reorder or lose words, or would raise the full flag at the wrong count, and fall-through mode would have its capacity off by one. Overflow and underflow attempts are followed by a full drain, which exposes any pointer that moved when it should not have. A design that honours the mode pin during a partial reset would return in the wrong mode. The retransmit cases replay the written words in both modes and check that replay stops where the write pointer stands. They also confirm that a request with the enable low changes nothing.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic {MODE_STD = 1'b0, MODE_FWFT = 1'b1} dcf_mode_e;
  // read-clock edges between a retransmit request and the rewind
  localparam int RT_WAIT = 4;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/dcf_wr.sv
module dcf_wr
  import dcf_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          clr_n,
  input  logic          mode_in,
  input  logic          wr_en,
  input  logic [AW:0]   rgray_s,
  output logic [AW:0]   wgray,
  output logic [AW-1:0] waddr,
  output logic          we,
  output logic          wr_flag
);
  logic [AW:0] wbin;
  logic [AW:0] wbin_nx;
  logic        full;
  dcf_mode_e   mode_q;

  function automatic logic [AW:0] b2g(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  always_ff @(posedge wclk) begin
    if (!rst_n) mode_q <= dcf_mode_e'(mode_in);
  end

  assign full    = (wgray == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
  assign we      = wr_en & ~full;
  assign wbin_nx = wbin + 1'b1;
  assign waddr   = wbin[AW-1:0];
  assign wr_flag = (mode_q == MODE_FWFT) ? ~full : full;

  always_ff @(posedge wclk or negedge clr_n) begin
    if (!clr_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (we) begin
      wbin  <= wbin_nx;
      wgray <= b2g(wbin_nx);
    end
  end

  // R10
  wgray_step_chk: assert property (@(posedge wclk) disable iff (!clr_n)
    $onehot0(wgray ^ $past(wgray)));

  // R5
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!clr_n)
    (wr_en && full) |=> $stable(wbin));
endmodule

// File: rtl/dcf_rd.sv
module dcf_rd
  import dcf_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          clr_n,
  input  logic          mode_in,
  input  logic          rd_en,
  input  logic          rt_n,
  input  logic          rt_mode,
  input  logic [AW:0]   wgray_s,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW:0]   rgray,
  output logic [AW-1:0] raddr,
  output logic [DW-1:0] rd_data,
  output logic          rd_flag
);
  localparam int CW = $clog2(RT_WAIT + 1);
  localparam logic [CW-1:0] RT_LAST = CW'(RT_WAIT);

  logic [AW:0]   rbin;
  logic [AW:0]   rbin_nx;
  logic [CW-1:0] rt_cnt;
  logic          ov;
  logic          fwft, ptr_empty, rt_req, rt_busy, rt_start, rt_hold, fetch;
  dcf_mode_e     mode_q;

  function automatic logic [AW:0] b2g(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  always_ff @(posedge rclk) begin
    if (!rst_n) mode_q <= dcf_mode_e'(mode_in);
  end

  assign fwft      = (mode_q == MODE_FWFT);
  assign ptr_empty = (rgray == wgray_s);
  assign rt_req    = ~rt_n & rt_mode;
  assign rt_busy   = (rt_cnt != '0);
  assign rt_start  = rt_req & ~rt_busy;
  assign rt_hold   = rt_busy | rt_start;
  assign fetch     = ~ptr_empty & ~rt_hold & (fwft ? (~ov | rd_en) : rd_en);
  assign rbin_nx   = rbin + 1'b1;
  assign raddr     = rbin[AW-1:0];
  assign rd_flag   = fwft ? ov : (ptr_empty | rt_busy);

  always_ff @(posedge rclk or negedge clr_n) begin
    if (!clr_n) begin
      rbin    <= '0;
      rgray   <= '0;
      rt_cnt  <= '0;
      ov      <= 1'b0;
      rd_data <= '0;
    end else begin
      if (rt_busy)     rt_cnt <= (rt_cnt == RT_LAST) ? '0 : rt_cnt + 1'b1;
      else if (rt_req) rt_cnt <= CW'(1);

      if (rt_cnt == RT_LAST) begin
        rbin  <= '0;
        rgray <= '0;
      end else if (fetch) begin
        rbin    <= rbin_nx;
        rgray   <= b2g(rbin_nx);
        rd_data <= mem_rdata;
      end

      if (rt_start)                          ov <= 1'b0;
      else if (fetch)                        ov <= fwft;
      else if (fwft && rd_en && !rt_hold)    ov <= 1'b0;
    end
  end

  // R10
  rgray_step_chk: assert property (@(posedge rclk) disable iff (!clr_n)
    ($past(rt_cnt) != RT_LAST) |-> $onehot0(rgray ^ $past(rgray)));

  // R6
  no_underflow_chk: assert property (@(posedge rclk) disable iff (!clr_n)
    (!fwft && rd_flag && rd_en && rt_cnt != RT_LAST) |=> ($stable(rd_data) && $stable(rbin)));

  // R11
  hold_out_chk: assert property (@(posedge rclk) disable iff (!clr_n)
    (fwft && ov && !rd_en && !rt_req) |=> (ov && $stable(rd_data)));

  // R8
  rt_rewind_chk: assert property (@(posedge rclk) disable iff (!clr_n)
    ($past(rt_cnt) == RT_LAST) |-> (rbin == '0 && !ov));

  // R7
  mode_keep_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    rst_n |=> $stable(mode_q));
endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          prst_n,
  input  logic          mode_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_flag,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_flag,
  input  logic          rt_n,
  input  logic          rt_mode
);
  localparam int PW = AW + 1;

  logic          clr_n;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] mem_rdata;
  logic          we;

  assign clr_n = rst_n & prst_n;

  dcf_sync #(.W(PW)) u_r2w (.clk(wclk), .clr_n(clr_n), .d(rgray), .q(rgray_s));
  dcf_sync #(.W(PW)) u_w2r (.clk(rclk), .clr_n(clr_n), .d(wgray), .q(wgray_s));

  dcf_wr #(.AW(AW)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .clr_n(clr_n), .mode_in(mode_sel),
    .wr_en(wr_en), .rgray_s(rgray_s), .wgray(wgray), .waddr(waddr),
    .we(we), .wr_flag(wr_flag)
  );

  dcf_mem #(.DW(DW), .AW(AW)) u_mem (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(mem_rdata)
  );

  dcf_rd #(.DW(DW), .AW(AW)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .clr_n(clr_n), .mode_in(mode_sel),
    .rd_en(rd_en), .rt_n(rt_n), .rt_mode(rt_mode), .wgray_s(wgray_s),
    .mem_rdata(mem_rdata), .rgray(rgray), .raddr(raddr),
    .rd_data(rd_data), .rd_flag(rd_flag)
  );
endmodule

// File: tb/tb_dual_clock_fifo.sv
`timescale 1ns/1ps
module tb_dual_clock_fifo;
  localparam int DW = 8;
  localparam int AW = 2;
  localparam int DEPTH = 1 << AW;

  logic wclk = 1'b0, rclk = 1'b0;
  logic rst_n = 1'b0, prst_n = 1'b1, mode_sel = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, rt_n = 1'b1, rt_mode = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic wr_flag, rd_flag;
  logic fw = 1'b0;
  int checks = 0, errors = 0;

  always #2   wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  dual_clock_fifo #(.DW(DW), .AW(AW)) dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .prst_n(prst_n), .mode_sel(mode_sel),
    .wr_en(wr_en), .wr_data(wr_data), .wr_flag(wr_flag), .rd_en(rd_en),
    .rd_data(rd_data), .rd_flag(rd_flag), .rt_n(rt_n), .rt_mode(rt_mode)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (10) @(negedge rclk);
    repeat (10) @(negedge wclk);
  endtask

  task automatic do_reset(input logic m);
    rst_n = 1'b0; mode_sel = m;
    repeat (4) @(negedge rclk);
    repeat (4) @(negedge wclk);
    rst_n = 1'b1; fw = m;
    settle();
  endtask

  task automatic do_prst(input logic m_in);
    prst_n = 1'b0; mode_sel = m_in;
    repeat (4) @(negedge rclk);
    repeat (4) @(negedge wclk);
    prst_n = 1'b1;
    settle();
  endtask

  task automatic push(input logic [DW-1:0] d);
    int t = 0;
    @(negedge wclk);
    while (!(fw ? wr_flag : !wr_flag) && t < 200) begin @(negedge wclk); t++; end
    if (t >= 200) chk("R4 write space timeout", 0, 1);
    wr_en = 1'b1; wr_data = d;
    @(negedge wclk);
    wr_en = 1'b0;
  endtask

  task automatic pop(output logic [DW-1:0] d);
    int t = 0;
    @(negedge rclk);
    while (!(fw ? rd_flag : !rd_flag) && t < 200) begin @(negedge rclk); t++; end
    if (t >= 200) chk("R2/R3 read data timeout", 0, 1);
    if (fw) begin
      d = rd_data; rd_en = 1'b1;
      @(negedge rclk);
      rd_en = 1'b0;
    end else begin
      rd_en = 1'b1;
      @(negedge rclk);
      rd_en = 1'b0;
      d = rd_data;
    end
  endtask

  task automatic rt_pulse(input logic en);
    @(negedge rclk);
    rt_mode = en; rt_n = 1'b0;
    @(negedge rclk);
    rt_n = 1'b1; rt_mode = 1'b0;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] got;
    int base;

    // R1 / R2 standard mode basics
    do_reset(1'b0);
    chk("R1 std full flag", wr_flag, 0);
    chk("R1 std empty flag", rd_flag, 1);
    push(8'hA5);
    settle();
    chk("R2 word held until read", rd_data, 0);
    chk("R2 not empty", rd_flag, 0);
    pop(got);
    chk("R2 first read", got, 8'hA5);

    // R2 R3 R4 R10 occupancy sweep in both modes
    for (int m = 0; m < 2; m++) begin
      do_reset(m[0]);
      if (m == 1) begin
        chk("R1 fwft input ready", wr_flag, 1);
        chk("R1 fwft output ready", rd_flag, 0);
      end
      for (int n = 1; n <= DEPTH + m; n++) begin
        base = (m * 100 + n * 10) & 255;
        for (int i = 0; i < n; i++) push(DW'(base + i));
        settle();
        if (m == 0) chk("R4 full at depth", wr_flag, (n == DEPTH) ? 1 : 0);
        else begin
          chk("R4 input ready", wr_flag, (n < DEPTH + 1) ? 1 : 0);
          chk("R3 falls through", rd_flag, 1);
          chk("R3 first word shown", rd_data, base);
        end
        for (int i = 0; i < n; i++) begin
          pop(got);
          chk(m == 0 ? "R2 R10 order" : "R3 R10 order", got, (base + i) & 255);
        end
        settle();
        chk("R2 R3 drained flag", rd_flag, m == 0 ? 1 : 0);
      end
    end

    // R5 overflow ignored
    do_reset(1'b0);
    for (int i = 1; i <= DEPTH; i++) push(DW'(i));
    settle();
    chk("R5 full", wr_flag, 1);
    @(negedge wclk); wr_en = 1'b1; wr_data = 8'hEE;
    @(negedge wclk); wr_en = 1'b0;
    settle();
    for (int i = 1; i <= DEPTH; i++) begin
      pop(got);
      chk("R5 contents kept", got, i);
    end
    settle();
    chk("R5 extra word dropped", rd_flag, 1);

    // R6 underflow in standard mode
    @(negedge rclk); rd_en = 1'b1;
    repeat (3) @(negedge rclk);
    rd_en = 1'b0;
    chk("R6 std data kept", rd_data, DEPTH);
    push(8'h33);
    pop(got);
    chk("R6 std pointer kept", got, 8'h33);

    // R6 / R11 in fall-through mode
    do_reset(1'b1);
    @(negedge rclk); rd_en = 1'b1;
    repeat (3) @(negedge rclk);
    rd_en = 1'b0;
    push(8'h44);
    settle();
    chk("R6 fwft ready after ignored read", rd_flag, 1);
    chk("R6 fwft data", rd_data, 8'h44);
    pop(got);
    push(8'h55); push(8'h66);
    settle();
    chk("R11 held word", rd_data, 8'h55);
    repeat (10) @(negedge rclk);
    chk("R11 still held", rd_data, 8'h55);
    pop(got); chk("R11 pop 1", got, 8'h55);
    pop(got); chk("R11 pop 2", got, 8'h66);

    // R7 partial reset keeps fall-through mode
    do_reset(1'b1);
    push(8'h01); push(8'h02); push(8'h03);
    settle();
    do_prst(1'b0);
    chk("R7 flushed input ready", wr_flag, 1);
    chk("R7 flushed output", rd_flag, 0);
    push(8'h77);
    settle();
    chk("R7 still fall-through", rd_flag, 1);
    chk("R7 data", rd_data, 8'h77);
    pop(got);
    do_reset(1'b0);
    chk("R1 new mode at full reset", rd_flag, 1);

    // R8 retransmit in standard mode
    do_reset(1'b0);
    push(8'h10); push(8'h11); push(8'h12);
    pop(got); pop(got);
    rt_pulse(1'b1);
    chk("R8 std busy shows empty", rd_flag, 1);
    settle();
    for (int i = 0; i < 3; i++) begin
      pop(got);
      chk("R8 std replay", got, 8'h10 + i);
    end
    settle();
    chk("R8 write pointer unchanged", rd_flag, 1);

    // R8 retransmit in fall-through mode
    do_reset(1'b1);
    push(8'h20); push(8'h21);
    settle();
    pop(got);
    rt_pulse(1'b1);
    chk("R8 fwft busy no output", rd_flag, 0);
    settle();
    chk("R8 fwft replay shown", rd_data, 8'h20);
    pop(got); chk("R8 fwft replay 1", got, 8'h20);
    pop(got); chk("R8 fwft replay 2", got, 8'h21);

    // R9 disabled retransmit
    do_reset(1'b0);
    push(8'h30); push(8'h31);
    pop(got);
    @(negedge rclk); rt_mode = 1'b0; rt_n = 1'b0;
    repeat (6) @(negedge rclk);
    rt_n = 1'b1;
    settle();
    pop(got);
    chk("R9 no rewind", got, 8'h31);
    settle();
    chk("R9 empty after", rd_flag, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule